// File: doc/BRIEF.md
# Speculative Indirect-Branch Path History Queue

This block keeps a speculative, in-order record of indirect branches for a path-based target predictor. Each record carries the branch address, the predicted target and a sequence number. Records join at the young end as branches are predicted. A resolved target can overwrite the youngest record. Retirement moves a committed-head marker forward. A pipeline flush cuts away every record younger than a given sequence number.

The queue keeps at least `PATH_LEN` committed records so that the hashing logic next to it always has enough path history. Once the head marker has reached `PATH_LEN`, each further retirement drops the oldest record instead of moving the marker. The block publishes two target vectors, both youngest first. The first holds the newest `PATH_LEN` targets. The second leaves out the youngest record, for index computation while that record is being corrected. The block also publishes the youngest branch address, the occupancy and the committed count. The storage is a ring of `DEPTH` slots. Sequence numbers are unsigned, fixed-width values that are assumed not to wrap.

Top module: `phb_path_hist`

## Requirements
- R1: A record request appends {address, target, sequence} at the young end: occupancy rises by one and the youngest target and youngest address outputs show the new values on the next cycle.
- R2: A record request while occupancy equals `DEPTH` first drops the oldest entry, decrementing the committed count if it is non-zero, so occupancy stays at `DEPTH`.
- R3: A commit with bound S acts only if the queue is non-empty, the committed count is below the occupancy, and the sequence number of the entry at the committed count (counted from the oldest) is at most S; otherwise it changes nothing.
- R4: An acting commit increments the committed count while that count is below `PATH_LEN`; otherwise it removes the oldest entry and leaves the count unchanged. A request moves at most one step.
- R5: A squash with bound S finds the oldest entry whose sequence number exceeds S and removes it and every younger entry; the committed count is then clamped to the new occupancy.
- R6: A target-correction request overwrites the target of the youngest entry (youngest after any same-cycle squash) and has no effect on an empty queue.
- R7: When requests coincide in one cycle they apply in the order squash, correction, commit, record.
- R8: `path_tgt_o` slot p (bits p*AW upward) holds the target of the (p+1)-th youngest entry, or zero when fewer entries exist; `path_cnt_o` equals min(occupancy, `PATH_LEN`).
- R9: `prior_tgt_o` slot p holds the target of the (p+2)-th youngest entry, or zero; `prior_cnt_o` equals min(max(occupancy-1, 0), `PATH_LEN`).
- R10: After reset the queue is empty: occupancy, committed count, both counts, both vectors and the youngest address read zero.
- R11: Sequence numbers compare as unsigned values, so a bound of 0x8000 lies above 0x7FFF and below 0x9000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_v | input | 1 | Record request |
| rec_pc | input | AW | Branch address to record |
| rec_tgt | input | AW | Predicted target to record |
| rec_seq | input | SEQW | Sequence number to record |
| fix_v | input | 1 | Correct the youngest target |
| fix_tgt | input | AW | Resolved target |
| cm_v | input | 1 | Commit request |
| cm_seq | input | SEQW | Commit bound |
| sq_v | input | 1 | Squash request |
| sq_seq | input | SEQW | Squash bound |
| path_tgt_o | output | PATH_LEN*AW | Youngest targets, youngest in slot 0 |
| path_cnt_o | output | $clog2(PATH_LEN+1) | Valid slots in path_tgt_o |
| prior_tgt_o | output | PATH_LEN*AW | Targets excluding the youngest entry |
| prior_cnt_o | output | $clog2(PATH_LEN+1) | Valid slots in prior_tgt_o |
| yng_pc_o | output | AW | Address of the youngest entry, zero if empty |
| occ_o | output | $clog2(DEPTH+1) | Occupancy |
| cmt_o | output | $clog2(DEPTH+1) | Committed-head count |

## Verification
The bench fills the ring past `DEPTH` so that records wrap and the oldest entry is dropped. A design that forgot to adjust the committed count there would keep a head marker beyond the surviving committed entries. The bench drives commits across the `PATH_LEN` threshold. A design that popped too early, or advanced twice in one request, would lose history that the hashing logic needs. The bench also squashes with bounds that cut nothing, cut the middle, or cut everything. It issues all four requests in one cycle, where a wrong ordering would correct or commit the wrong entry. Finally it uses sequence numbers around 0x8000, where a signed comparison would squash the wrong entries.

// File: rtl/phb_pkg.sv
package phb_pkg;
   // Saturating clamp of a signed count into [0, hi].
   function automatic int clamp_cnt(input int v, input int hi);
      if (v < 0) return 0;
      if (v > hi) return hi;
      return v;
   endfunction
endpackage

// File: rtl/phb_cut_find.sv
module phb_cut_find #(
   parameter int SEQW  = 16,
   parameter int DEPTH = 16,
   parameter int OW    = 5
) (
   input  logic [SEQW-1:0] seq_age [DEPTH],
   input  logic [OW-1:0]   occ,
   input  logic [SEQW-1:0] bound,
   output logic [OW-1:0]   cut
);
   // Oldest live position whose sequence exceeds the bound; occ if none.
   always_comb begin
      cut = occ;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (i < int'(occ) && seq_age[i] > bound) cut = OW'(i);
      end
   end
endmodule

// File: rtl/phb_commit_ctl.sv
module phb_commit_ctl #(
   parameter int SEQW     = 16,
   parameter int OW       = 5,
   parameter int PATH_LEN = 4
) (
   input  logic            req,
   input  logic [SEQW-1:0] bound,
   input  logic [OW-1:0]   occ,
   input  logic [OW-1:0]   hd,
   input  logic [SEQW-1:0] head_seq,
   output logic            adv,
   output logic            pop
);
   logic act;
   always_comb begin
      act = req && (occ != '0) && (hd < occ) && (head_seq <= bound);
      pop = act && (int'(hd) >= PATH_LEN);
      adv = act && !pop;
   end
endmodule

// File: rtl/phb_hist_view.sv
module phb_hist_view #(
   parameter int AW       = 32,
   parameter int DEPTH    = 16,
   parameter int PATH_LEN = 4,
   parameter int SKIP     = 0,
   parameter int OW       = 5,
   parameter int PW       = 4,
   parameter int CNTW     = 3
) (
   input  logic [AW-1:0]          tgt_age [DEPTH],
   input  logic [OW-1:0]          occ,
   output logic [PATH_LEN*AW-1:0] vec,
   output logic [CNTW-1:0]        cnt
);
   import phb_pkg::*;
   always_comb begin
      vec = '0;
      for (int p = 0; p < PATH_LEN; p++) begin
         if (p + SKIP < int'(occ))
            vec[p*AW +: AW] = tgt_age[PW'(int'(occ) - 1 - SKIP - p)];
      end
      cnt = CNTW'(clamp_cnt(int'(occ) - SKIP, PATH_LEN));
   end
endmodule

// File: rtl/phb_path_hist.sv
module phb_path_hist #(
   parameter int AW       = 32,
   parameter int SEQW     = 16,
   parameter int DEPTH    = 16,
   parameter int PATH_LEN = 4,
   localparam int PW      = $clog2(DEPTH),
   localparam int OW      = $clog2(DEPTH + 1),
   localparam int CNTW    = $clog2(PATH_LEN + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rec_v,
   input  logic [AW-1:0]          rec_pc,
   input  logic [AW-1:0]          rec_tgt,
   input  logic [SEQW-1:0]        rec_seq,
   input  logic                   fix_v,
   input  logic [AW-1:0]          fix_tgt,
   input  logic                   cm_v,
   input  logic [SEQW-1:0]        cm_seq,
   input  logic                   sq_v,
   input  logic [SEQW-1:0]        sq_seq,
   output logic [PATH_LEN*AW-1:0] path_tgt_o,
   output logic [CNTW-1:0]        path_cnt_o,
   output logic [PATH_LEN*AW-1:0] prior_tgt_o,
   output logic [CNTW-1:0]        prior_cnt_o,
   output logic [AW-1:0]          yng_pc_o,
   output logic [OW-1:0]          occ_o,
   output logic [OW-1:0]          cmt_o
);
   // Elaboration-time parameter checks
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("phb_path_hist: DEPTH must be a power of two >= 2");
   end
   if (PATH_LEN < 1 || PATH_LEN >= DEPTH) begin : g_bad_plen
      $error("phb_path_hist: PATH_LEN must be in [1, DEPTH-1]");
   end
   if (AW < 1 || SEQW < 1) begin : g_bad_width
      $error("phb_path_hist: AW and SEQW must be positive");
   end

   // Ring storage
   logic [AW-1:0]   pc_q  [DEPTH];
   logic [AW-1:0]   tgt_q [DEPTH];
   logic [SEQW-1:0] seq_q [DEPTH];
   logic [PW-1:0]   old_q;
   logic [OW-1:0]   occ_q, hd_q;

   // Age-ordered views (index 0 = oldest)
   logic [AW-1:0]   tgt_age [DEPTH];
   logic [SEQW-1:0] seq_age [DEPTH];
   for (genvar i = 0; i < DEPTH; i++) begin : g_age
      logic [PW-1:0] slot;
      assign slot       = old_q + PW'(i);
      assign tgt_age[i] = tgt_q[slot];
      assign seq_age[i] = seq_q[slot];
   end

   // Stage 1: squash
   logic [OW-1:0] cut, s_occ, s_hd;
   phb_cut_find #(.SEQW(SEQW), .DEPTH(DEPTH), .OW(OW)) u_cut (
      .seq_age(seq_age), .occ(occ_q), .bound(sq_seq), .cut(cut)
   );
   always_comb begin
      s_occ = sq_v ? cut : occ_q;
      s_hd  = (hd_q > s_occ) ? s_occ : hd_q;
   end

   // Stage 2: correction of the youngest surviving entry
   logic          fix_we;
   logic [PW-1:0] fix_slot;
   always_comb begin
      fix_we   = fix_v && (s_occ != '0);
      fix_slot = old_q + PW'(s_occ - OW'(1));
   end

   // Stage 3: commit
   logic cm_adv, cm_pop;
   phb_commit_ctl #(.SEQW(SEQW), .OW(OW), .PATH_LEN(PATH_LEN)) u_cm (
      .req(cm_v), .bound(cm_seq), .occ(s_occ), .hd(s_hd),
      .head_seq(seq_age[PW'(s_hd)]), .adv(cm_adv), .pop(cm_pop)
   );
   logic [PW-1:0] c_old;
   logic [OW-1:0] c_occ, c_hd;
   always_comb begin
      c_old = old_q + PW'(cm_pop);
      c_occ = s_occ - OW'(cm_pop);
      c_hd  = cm_adv ? s_hd + OW'(1) : s_hd;
   end

   // Stage 4: record (drops the oldest when full)
   logic          full, rec_we;
   logic [PW-1:0] rec_slot, n_old;
   logic [OW-1:0] n_occ, n_hd;
   always_comb begin
      full     = (c_occ == OW'(DEPTH));
      rec_we   = rec_v;
      rec_slot = c_old + PW'(c_occ);
      n_old    = (rec_v && full) ? c_old + PW'(1) : c_old;
      n_occ    = (rec_v && !full) ? c_occ + OW'(1) : c_occ;
      n_hd     = (rec_v && full && c_hd != '0) ? c_hd - OW'(1) : c_hd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         old_q <= '0;
         occ_q <= '0;
         hd_q  <= '0;
      end else begin
         old_q <= n_old;
         occ_q <= n_occ;
         hd_q  <= n_hd;
      end
   end

   always_ff @(posedge clk) begin
      if (fix_we) tgt_q[fix_slot] <= fix_tgt;
      if (rec_we) begin
         pc_q[rec_slot]  <= rec_pc;
         tgt_q[rec_slot] <= rec_tgt;
         seq_q[rec_slot] <= rec_seq;
      end
   end

   // History views for the index hash
   phb_hist_view #(.AW(AW), .DEPTH(DEPTH), .PATH_LEN(PATH_LEN), .SKIP(0),
                   .OW(OW), .PW(PW), .CNTW(CNTW)) u_view_all (
      .tgt_age(tgt_age), .occ(occ_q), .vec(path_tgt_o), .cnt(path_cnt_o)
   );
   phb_hist_view #(.AW(AW), .DEPTH(DEPTH), .PATH_LEN(PATH_LEN), .SKIP(1),
                   .OW(OW), .PW(PW), .CNTW(CNTW)) u_view_prior (
      .tgt_age(tgt_age), .occ(occ_q), .vec(prior_tgt_o), .cnt(prior_cnt_o)
   );

   always_comb begin
      yng_pc_o = (occ_q != '0) ? pc_q[old_q + PW'(occ_q - OW'(1))] : '0;
      occ_o    = occ_q;
      cmt_o    = hd_q;
   end
endmodule

// File: rtl/phb_path_hist_chk.sv
module phb_path_hist_chk #(
   parameter int AW       = 32,
   parameter int SEQW     = 16,
   parameter int DEPTH    = 16,
   parameter int PATH_LEN = 4,
   localparam int OW      = $clog2(DEPTH + 1),
   localparam int CNTW    = $clog2(PATH_LEN + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   rec_v,
   input logic [AW-1:0]          rec_pc,
   input logic [AW-1:0]          rec_tgt,
   input logic                   fix_v,
   input logic [AW-1:0]          fix_tgt,
   input logic                   cm_v,
   input logic                   sq_v,
   input logic [PATH_LEN*AW-1:0] path_tgt_o,
   input logic [CNTW-1:0]        path_cnt_o,
   input logic [PATH_LEN*AW-1:0] prior_tgt_o,
   input logic [CNTW-1:0]        prior_cnt_o,
   input logic [AW-1:0]          yng_pc_o,
   input logic [OW-1:0]          occ_o,
   input logic [OW-1:0]          cmt_o
);
   a_r1_append: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_v && !sq_v && !cm_v && int'(occ_o) < DEPTH) |=>
      (int'(occ_o) == int'($past(occ_o)) + 1 && yng_pc_o == $past(rec_pc)
       && path_tgt_o[AW-1:0] == $past(rec_tgt)));

   a_r2_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_v && !sq_v && !cm_v && int'(occ_o) == DEPTH) |=>
      (int'(occ_o) == DEPTH && path_tgt_o[AW-1:0] == $past(rec_tgt)));

   a_r3_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_v && occ_o == '0 && !rec_v && !sq_v) |=> (cmt_o == '0 && occ_o == '0));

   a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!sq_v && !rec_v) |=> (int'(cmt_o) <= int'($past(cmt_o)) + 1));

   a_r5_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_v && !rec_v) |=> (occ_o <= $past(occ_o)));

   a_r6_fix_youngest: assert property (@(posedge clk) disable iff (!rst_n)
      (fix_v && !sq_v && !cm_v && !rec_v && occ_o != '0) |=>
      (path_tgt_o[AW-1:0] == $past(fix_tgt)));

   a_r8_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_o <= occ_o && int'(occ_o) <= DEPTH
       && ((occ_o == '0) == (path_cnt_o == '0))));

   a_r9_prior_cnt: assert property (@(posedge clk) disable iff (!rst_n)
      (prior_cnt_o <= path_cnt_o));

   if (PATH_LEN >= 2) begin : g_shift
      a_r9_prior_shift: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(occ_o) >= 2) |-> (prior_tgt_o[AW-1:0] == path_tgt_o[2*AW-1:AW]));
   end
endmodule

bind phb_path_hist phb_path_hist_chk #(
   .AW(AW), .SEQW(SEQW), .DEPTH(DEPTH), .PATH_LEN(PATH_LEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rec_v(rec_v), .rec_pc(rec_pc), .rec_tgt(rec_tgt),
   .fix_v(fix_v), .fix_tgt(fix_tgt), .cm_v(cm_v), .sq_v(sq_v),
   .path_tgt_o(path_tgt_o), .path_cnt_o(path_cnt_o),
   .prior_tgt_o(prior_tgt_o), .prior_cnt_o(prior_cnt_o),
   .yng_pc_o(yng_pc_o), .occ_o(occ_o), .cmt_o(cmt_o)
);

// File: tb/phb_path_hist_tb.sv
`timescale 1ns/1ps
module phb_path_hist_tb_top;
   localparam int AW = 32, SEQW = 16, DEPTH = 16, PL = 4;
   localparam int OW = $clog2(DEPTH + 1), CNTW = $clog2(PL + 1);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n;
   logic rec_v, fix_v, cm_v, sq_v;
   logic [AW-1:0] rec_pc, rec_tgt, fix_tgt;
   logic [SEQW-1:0] rec_seq, cm_seq, sq_seq;
   logic [PL*AW-1:0] path_tgt_o, prior_tgt_o;
   logic [CNTW-1:0] path_cnt_o, prior_cnt_o;
   logic [AW-1:0] yng_pc_o;
   logic [OW-1:0] occ_o, cmt_o;

   phb_path_hist #(.AW(AW), .SEQW(SEQW), .DEPTH(DEPTH), .PATH_LEN(PL)) dut_i (
      .clk(clk), .rst_n(rst_n), .rec_v(rec_v), .rec_pc(rec_pc), .rec_tgt(rec_tgt),
      .rec_seq(rec_seq), .fix_v(fix_v), .fix_tgt(fix_tgt), .cm_v(cm_v),
      .cm_seq(cm_seq), .sq_v(sq_v), .sq_seq(sq_seq), .path_tgt_o(path_tgt_o),
      .path_cnt_o(path_cnt_o), .prior_tgt_o(prior_tgt_o), .prior_cnt_o(prior_cnt_o),
      .yng_pc_o(yng_pc_o), .occ_o(occ_o), .cmt_o(cmt_o)
   );

   // Behavioural reference: a queue plus a committed count
   typedef struct {
      logic [AW-1:0]   pc;
      logic [AW-1:0]   tgt;
      logic [SEQW-1:0] seq;
   } ent_t;
   ent_t mq[$];
   int   mhd;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete();
         mhd = 0;
      end else begin
         if (sq_v) begin
            int cut;
            cut = mq.size();
            for (int i = mq.size() - 1; i >= 0; i--) if (mq[i].seq > sq_seq) cut = i;
            while (mq.size() > cut) void'(mq.pop_back());
            if (mhd > mq.size()) mhd = mq.size();
         end
         if (fix_v && mq.size() > 0) mq[mq.size()-1].tgt = fix_tgt;
         if (cm_v && mq.size() > 0 && mhd < mq.size() && mq[mhd].seq <= cm_seq) begin
            if (mhd >= PL) void'(mq.pop_front());
            else mhd++;
         end
         if (rec_v) begin
            ent_t e;
            if (mq.size() == DEPTH) begin
               void'(mq.pop_front());
               if (mhd > 0) mhd--;
            end
            e.pc = rec_pc; e.tgt = rec_tgt; e.seq = rec_seq;
            mq.push_back(e);
         end
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      int sz;
      sz = mq.size();
      chk(tag, "occupancy", AW'(occ_o), AW'(sz));
      chk(tag, "committed", AW'(cmt_o), AW'(mhd));
      chk(tag, "path count", AW'(path_cnt_o), AW'((sz > PL) ? PL : sz));
      chk(tag, "prior count", AW'(prior_cnt_o),
          AW'((sz == 0) ? 0 : ((sz - 1 > PL) ? PL : sz - 1)));
      chk(tag, "youngest pc", yng_pc_o, (sz > 0) ? mq[sz-1].pc : '0);
      for (int p = 0; p < PL; p++) begin
         chk(tag, $sformatf("path slot %0d", p), path_tgt_o[p*AW +: AW],
             (p < sz) ? mq[sz-1-p].tgt : '0);
         chk(tag, $sformatf("prior slot %0d", p), prior_tgt_o[p*AW +: AW],
             (p + 1 < sz) ? mq[sz-2-p].tgt : '0);
      end
   endtask

   task automatic idle_inputs();
      rec_v = 0; fix_v = 0; cm_v = 0; sq_v = 0;
      rec_pc = '0; rec_tgt = '0; rec_seq = '0; fix_tgt = '0; cm_seq = '0; sq_seq = '0;
   endtask

   // Inputs are applied at a negedge; results are checked at the next negedge.
   task automatic step(input string tag);
      @(posedge clk);
      #1 idle_inputs();
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic rec(input logic [SEQW-1:0] s, input string tag);
      rec_v = 1; rec_seq = s; rec_pc = 32'h1000_0000 + 32'(s) * 4;
      rec_tgt = 32'hA000_0000 ^ (32'(s) << 2);
      step(tag);
   endtask

   task automatic commit(input logic [SEQW-1:0] s, input string tag);
      cm_v = 1; cm_seq = s; step(tag);
   endtask

   task automatic squash(input logic [SEQW-1:0] s, input string tag);
      sq_v = 1; sq_seq = s; step(tag);
   endtask

   int gseq;

   initial begin
      idle_inputs();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      compare_all("R10");                          // R10 reset state

      rec(10, "R1"); rec(20, "R1"); rec(30, "R1"); // R1 append
      fix_v = 1; fix_tgt = 32'hDEAD_0001; step("R6"); // R6 correct youngest
      commit(5, "R3");                             // R3 bound too small
      commit(10, "R4"); commit(10, "R3");          // R4 advance, R3 head seq 20 > 10
      for (int k = 0; k < 4; k++) rec(16'(40 + 10*k), "R1");
      for (int k = 0; k < 6; k++) commit(16'd1000, "R4"); // R4 crosses PATH_LEN, then pops
      for (int k = 0; k < 20; k++) rec(16'(100 + k), "R2"); // R2 wrap and drop
      squash(110, "R5");                            // R5 cut in the middle
      squash(16'hFFFF, "R5");                       // R5 nothing cut
      commit(16'hFFFF, "R4");
      squash(0, "R5");                              // R5 everything cut
      commit(16'hFFFF, "R3");                       // R3 commit on empty
      fix_v = 1; fix_tgt = 32'h1234_5678; step("R6"); // R6 no effect when empty

      // R7 all four requests in one cycle
      rec(200, "R7"); rec(201, "R7"); rec(202, "R7");
      sq_v = 1; sq_seq = 201; fix_v = 1; fix_tgt = 32'hF1F1_0000;
      cm_v = 1; cm_seq = 300; rec_v = 1; rec_seq = 203;
      rec_pc = 32'h2222_0000; rec_tgt = 32'h3333_0000;
      step("R7");
      squash(0, "R7");

      // R11 unsigned comparison across the top bit
      rec(16'h7FFF, "R11"); rec(16'h8000, "R11"); rec(16'h9000, "R11");
      squash(16'h8000, "R11");
      commit(16'h8000, "R11");
      squash(0, "R11");

      // Mixed traffic
      gseq = 1;
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 55) begin
            gseq += int'($urandom_range(1, 3));
            rec_v = 1; rec_seq = SEQW'(gseq);
            rec_pc = $urandom(); rec_tgt = $urandom();
         end
         if ($urandom_range(0, 99) < 35) begin
            cm_v = 1; cm_seq = SEQW'(gseq - int'($urandom_range(0, 12)));
         end
         if ($urandom_range(0, 99) < 8) begin
            sq_v = 1; sq_seq = SEQW'(gseq - int'($urandom_range(0, 10)));
         end
         if ($urandom_range(0, 99) < 15) begin
            fix_v = 1; fix_tgt = $urandom();
         end
         step("R8");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule